// File: doc/BRIEF.md
# Indirect Byte-Burst Front End for a Low Pin Count Bus

This block sits between a host register port and a bus cycle engine. The host never drives the bus itself. It programs an operation count, a command and a target address, loads any outgoing bytes into a write queue, and then writes a start strobe. The block then hands the operations one at a time to the attached cycle engine, which does the pin-level signalling. Every operation carries exactly one data byte, and one burst carries at most 16 operations.

During a read burst, the byte that comes back from each operation goes into a read queue. The host drains that queue through a single data register once the block reports that it is idle. The host learns the outcome by polling a status register that holds an idle bit and a finished-successfully bit. A sticky interrupt flag, cleared by writing 1 to it, marks the end of every burst, whether the burst succeeded or failed.

The command can pin every operation of a burst to one port address, which suits streaming into a data port. It can instead step the address by one after each operation.

Top module: `lpc_indirect_fe`

## Requirements
- R1: After reset, status (offset 0x04) reads 0x1 (idle, not finished). The interrupt register (0x08) reads 0. The read-data register (0x28) reads 0. The `irq_o` output is low.
- R2: Writing a value with bit 0 set to offset 0x00 while idle launches a burst. The burst presents to the engine exactly as many operations as the length register (0x10) holds.
- R3: A length of 0, or any length above 16, produces a burst of 16 operations.
- R4: Command register (0x14) bit 0 selects write (1) or read (0) and appears on `eng_write`. Bits [2:1] select the cycle kind (00 I/O, 01 memory, 10 firmware hub) and appear on `eng_kind`. Both stay constant for the whole burst.
- R5: With command bit 3 set, every operation uses the target address (0x20). With bit 3 clear, operation i uses target address + i.
- R6: Bytes written to offset 0x24 are presented on `eng_wbyte` in the order they were written, one byte per write operation. When the write queue is empty, 0x00 is presented.
- R7: After a read burst, successive reads of offset 0x28 return the returned bytes in operation order. Once the queue is empty, a read returns 0 and does not disturb later results.
- R8: Status bit 0 reads 0 while a burst is in progress. After a successful burst, status reads 0x3. An engine error (`eng_err` together with `eng_done`) ends the burst at once: no further operations are issued and status reads 0x1.
- R9: At the end of every burst, interrupt register bit 1 and `irq_o` are set. Writing 1 to bit 1 clears them. Writing 0 leaves them set.
- R10: A start strobe written while a burst is in progress is ignored. The number of operations issued does not change.
- R11: A new start discards any bytes still unread in the read queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops the read queue at 0x28) |
| host_addr | input | 8 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the same cycle as the address |
| irq_o | output | 1 | Burst-ended interrupt flag |
| eng_req | output | 1 | Operation request to the cycle engine, held until done |
| eng_write | output | 1 | 1 for write, 0 for read |
| eng_kind | output | 2 | Cycle kind: 00 I/O, 01 memory, 10 firmware hub |
| eng_addr | output | ADDR_W | Address of the current operation |
| eng_wbyte | output | 8 | Byte for the current write operation |
| eng_done | input | 1 | Engine finished the current operation |
| eng_err | input | 1 | Qualifies eng_done as failed |
| eng_rbyte | input | 8 | Byte returned by a read operation, valid with eng_done |

## Verification
A wrong operation counter shows up in the very burst that is running: the engine sees too many or too few requests before the idle bit returns. A slip in the address register shows on `eng_addr` at the next operation. A write queue that is out of step, or a read queue that was not flushed, delivers the wrong byte at the next engine operation or at the next host read. Each of these faults becomes visible within one burst, so a scoreboard that compares every engine operation and every drained byte against a model built from the register writes catches it within a few cycles.

// File: rtl/lpc_fe_pkg.sv
package lpc_fe_pkg;

  localparam int HOST_DW = 32;
  localparam int OFS_W   = 8;

  // host register offsets (software decodes these)
  localparam logic [OFS_W-1:0] OFS_START  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_STATUS = 8'h04;
  localparam logic [OFS_W-1:0] OFS_IRQ    = 8'h08;
  localparam logic [OFS_W-1:0] OFS_LEN    = 8'h10;
  localparam logic [OFS_W-1:0] OFS_CMD    = 8'h14;
  localparam logic [OFS_W-1:0] OFS_TADDR  = 8'h20;
  localparam logic [OFS_W-1:0] OFS_WDATA  = 8'h24;
  localparam logic [OFS_W-1:0] OFS_RDATA  = 8'h28;

  typedef enum logic [1:0] {
    CYC_IO    = 2'b00,
    CYC_MEM   = 2'b01,
    CYC_FWHUB = 2'b10
  } cyc_kind_e;

  // packed MSB first: bit3 same_addr, bits[2:1] kind, bit0 is_write
  typedef struct packed {
    logic      same_addr;
    cyc_kind_e kind;
    logic      is_write;
  } burst_cmd_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/lpc_fe_byte_fifo.sv
module lpc_fe_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = bump(wr_q);
      if (pop_ok)  rd_d = bump(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_q] <= din;
  end

endmodule

// File: rtl/lpc_fe_regfile.sv
module lpc_fe_regfile
  import lpc_fe_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_OPS = 16,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [OFS_W-1:0]   host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic [CNT_W-1:0]   len_q,
  output burst_cmd_t         cmd_q,
  output logic [ADDR_W-1:0]  taddr_q,
  output logic               start,
  output logic               wq_push,
  output logic [7:0]         wq_byte,
  output logic               rq_pop,
  input  logic               seq_idle,
  input  logic               seq_finished,
  input  logic               burst_end,
  input  logic               rq_empty,
  input  logic [7:0]         rq_head,
  output logic               irq_q
);
  logic [CNT_W-1:0]  len_d;
  burst_cmd_t        cmd_d;
  logic [ADDR_W-1:0] taddr_d;
  logic              irq_d;
  logic [CNT_W-1:0]  len_clamped;

  assign len_clamped = ((host_wdata == '0) || (host_wdata > HOST_DW'(MAX_OPS)))
                       ? CNT_W'(MAX_OPS) : host_wdata[CNT_W-1:0];

  assign start   = host_wr && (host_addr == OFS_START) && host_wdata[0] && seq_idle;
  assign wq_push = host_wr && (host_addr == OFS_WDATA);
  assign wq_byte = host_wdata[7:0];
  assign rq_pop  = host_rd && (host_addr == OFS_RDATA) && !rq_empty;

  always_comb begin
    len_d   = len_q;
    cmd_d   = cmd_q;
    taddr_d = taddr_q;
    irq_d   = irq_q;
    if (host_wr) begin
      case (host_addr)
        OFS_LEN:   len_d   = len_clamped;
        OFS_CMD:   cmd_d   = burst_cmd_t'(host_wdata[3:0]);
        OFS_TADDR: taddr_d = host_wdata[ADDR_W-1:0];
        OFS_IRQ:   if (host_wdata[1]) irq_d = 1'b0;
        default:   ;
      endcase
    end
    if (burst_end) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= CNT_W'(MAX_OPS);
      cmd_q   <= '0;
      taddr_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      len_q   <= len_d;
      cmd_q   <= cmd_d;
      taddr_q <= taddr_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_STATUS: host_rdata = {{(HOST_DW-2){1'b0}}, seq_finished, seq_idle};
      OFS_IRQ:    host_rdata = {{(HOST_DW-2){1'b0}}, irq_q, 1'b0};
      OFS_LEN:    host_rdata = {{(HOST_DW-CNT_W){1'b0}}, len_q};
      OFS_CMD:    host_rdata = {{(HOST_DW-4){1'b0}}, cmd_q};
      OFS_TADDR:  host_rdata = HOST_DW'(taddr_q);
      OFS_RDATA:  host_rdata = rq_empty ? '0 : {{(HOST_DW-8){1'b0}}, rq_head};
      default:    host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/lpc_fe_seq.sv
module lpc_fe_seq
  import lpc_fe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  burst_cmd_t        cmd,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              wq_empty,
  output logic              wq_pop,
  output logic              rq_push,
  output logic              eng_req,
  output logic [ADDR_W-1:0] eng_addr,
  output burst_cmd_t        run_cmd,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              idle,
  output logic              finished,
  output logic              burst_end
);
  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  burst_cmd_t        cmd_q, cmd_d;
  logic              fin_q, fin_d;

  assign eng_req  = (state_q == SEQ_RUN);
  assign eng_addr = addr_q;
  assign run_cmd  = cmd_q;
  assign idle     = (state_q == SEQ_IDLE);
  assign finished = fin_q;

  always_comb begin
    state_d   = state_q;
    remain_d  = remain_q;
    addr_d    = addr_q;
    cmd_d     = cmd_q;
    fin_d     = fin_q;
    burst_end = 1'b0;
    wq_pop    = 1'b0;
    rq_push   = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d  = SEQ_RUN;
          remain_d = len;
          addr_d   = base_addr;
          cmd_d    = cmd;
          fin_d    = 1'b0;
        end
      end
      SEQ_RUN: begin
        if (eng_done) begin
          wq_pop = cmd_q.is_write && !wq_empty;
          if (eng_err) begin
            state_d   = SEQ_IDLE;
            fin_d     = 1'b0;
            burst_end = 1'b1;
          end else begin
            rq_push = !cmd_q.is_write;
            if (remain_q == CNT_W'(1)) begin
              state_d   = SEQ_IDLE;
              fin_d     = 1'b1;
              burst_end = 1'b1;
            end else begin
              remain_d = remain_q - CNT_W'(1);
              if (!cmd_q.same_addr) addr_d = addr_q + ADDR_W'(1);
            end
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      remain_q <= '0;
      addr_q   <= '0;
      cmd_q    <= '0;
      fin_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      addr_q   <= addr_d;
      cmd_q    <= cmd_d;
      fin_q    <= fin_d;
    end
  end

endmodule

// File: rtl/lpc_indirect_fe.sv
module lpc_indirect_fe
  import lpc_fe_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_OPS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              irq_o,
  output logic              eng_req,
  output logic              eng_write,
  output logic [1:0]        eng_kind,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [7:0]        eng_wbyte,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic [7:0]        eng_rbyte
);
  localparam int CNT_W = $clog2(MAX_OPS + 1);

  // reset asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [CNT_W-1:0]  len_q;
  burst_cmd_t        cmd_q, run_cmd;
  logic [ADDR_W-1:0] taddr_q;
  logic              start, wq_push, rq_pop, wq_pop, rq_push;
  logic [7:0]        wq_byte, wq_head, rq_head;
  logic              wq_empty, rq_empty;
  logic              seq_idle, seq_finished, burst_end;

  lpc_fe_regfile #(.ADDR_W(ADDR_W), .MAX_OPS(MAX_OPS), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .len_q(len_q), .cmd_q(cmd_q), .taddr_q(taddr_q),
    .start(start), .wq_push(wq_push), .wq_byte(wq_byte), .rq_pop(rq_pop),
    .seq_idle(seq_idle), .seq_finished(seq_finished), .burst_end(burst_end),
    .rq_empty(rq_empty), .rq_head(rq_head), .irq_q(irq_o)
  );

  lpc_fe_byte_fifo #(.DEPTH(MAX_OPS), .W(8)) u_wq (
    .clk(clk), .rst_n(rst_sync_n), .flush(1'b0),
    .push(wq_push), .din(wq_byte), .pop(wq_pop),
    .dout(wq_head), .empty(wq_empty)
  );

  lpc_fe_byte_fifo #(.DEPTH(MAX_OPS), .W(8)) u_rq (
    .clk(clk), .rst_n(rst_sync_n), .flush(start),
    .push(rq_push), .din(eng_rbyte), .pop(rq_pop),
    .dout(rq_head), .empty(rq_empty)
  );

  lpc_fe_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .start(start), .len(len_q), .cmd(cmd_q), .base_addr(taddr_q),
    .wq_empty(wq_empty), .wq_pop(wq_pop), .rq_push(rq_push),
    .eng_req(eng_req), .eng_addr(eng_addr), .run_cmd(run_cmd),
    .eng_done(eng_done), .eng_err(eng_err),
    .idle(seq_idle), .finished(seq_finished), .burst_end(burst_end)
  );

  assign eng_write = run_cmd.is_write;
  assign eng_kind  = run_cmd.kind;
  assign eng_wbyte = wq_empty ? 8'h00 : wq_head;

endmodule

// File: rtl/lpc_fe_checker.sv
module lpc_fe_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_req,
  input logic              eng_done,
  input logic              eng_err,
  input logic [ADDR_W-1:0] eng_addr,
  input logic [1:0]        eng_kind,
  input logic              eng_write,
  input logic              same_addr,
  input logic              irq_o,
  input logic              host_rd,
  input logic [7:0]        host_addr,
  input logic [31:0]       host_rdata,
  input logic              rq_empty
);
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && $past(eng_req) && $past(eng_done) && !$past(eng_err) && same_addr)
      |-> (eng_addr == $past(eng_addr)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && $past(eng_req) && $past(eng_done) && !$past(eng_err) && !same_addr)
      |-> (eng_addr == $past(eng_addr) + ADDR_W'(1)));

  // R4
  kind_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && $past(eng_req)) |-> ($stable(eng_kind) && $stable(eng_write)));

  // R8
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && eng_err) |=> !eng_req);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(eng_req && eng_done));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && (host_addr == lpc_fe_pkg::OFS_RDATA) && rq_empty) |-> (host_rdata == 32'h0));

endmodule

bind lpc_indirect_fe lpc_fe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .eng_req(eng_req), .eng_done(eng_done), .eng_err(eng_err),
  .eng_addr(eng_addr), .eng_kind(eng_kind), .eng_write(eng_write),
  .same_addr(run_cmd.same_addr), .irq_o(irq_o),
  .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata),
  .rq_empty(rq_empty)
);

// File: tb/sim_lpc_indirect_fe.sv
module sim_lpc_indirect_fe;
  localparam logic [7:0] A_START = 8'h00, A_STATUS = 8'h04, A_IRQ = 8'h08,
                         A_LEN = 8'h10, A_CMD = 8'h14, A_TADDR = 8'h20,
                         A_WDATA = 8'h24, A_RDATA = 8'h28;

  logic        clk, rst_n;
  logic        host_wr, host_rd;
  logic [7:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        irq_o, eng_req, eng_write, eng_done, eng_err;
  logic [1:0]  eng_kind;
  logic [31:0] eng_addr;
  logic [7:0]  eng_wbyte, eng_rbyte;

  lpc_indirect_fe u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_o(irq_o), .eng_req(eng_req), .eng_write(eng_write), .eng_kind(eng_kind),
    .eng_addr(eng_addr), .eng_wbyte(eng_wbyte), .eng_done(eng_done),
    .eng_err(eng_err), .eng_rbyte(eng_rbyte)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic       w;
    logic [1:0] kind;
    logic [31:0] addr;
    logic [7:0] wb;
  } op_t;

  op_t        exp_ops[$];
  logic [7:0] exp_rd[$];
  logic [7:0] wq_model[$];
  int n_checks = 0, n_fail = 0;
  int op_idx = 0, err_at = -1, eng_lat = 2;
  bit done_flag = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // engine model and scoreboard monitor
  initial begin : engine
    bit in_op;
    int cnt;
    logic [31:0] op_addr;
    in_op = 0; cnt = 0; op_addr = '0;
    eng_done = 0; eng_err = 0; eng_rbyte = 0;
    forever begin
      @(negedge clk);
      eng_done = 0; eng_err = 0;
      if (!in_op && eng_req) begin
        op_t e;
        if (exp_ops.size() == 0) begin
          chk("R2 unexpected op", 1, 0);
        end else begin
          e = exp_ops.pop_front();
          chk("R4 write bit", {31'b0, eng_write}, {31'b0, e.w});
          chk("R4 kind", {30'b0, eng_kind}, {30'b0, e.kind});
          chk("R5 address", eng_addr, e.addr);
          if (e.w) chk("R6 write byte", {24'b0, eng_wbyte}, {24'b0, e.wb});
        end
        op_addr = eng_addr;
        cnt = eng_lat;
        in_op = 1;
      end else if (in_op) begin
        if (cnt == 0) begin
          eng_done  = 1;
          eng_err   = (op_idx == err_at);
          eng_rbyte = op_addr[7:0] ^ 8'hA5;
          op_idx++;
          in_op = 0;
        end else begin
          cnt--;
        end
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk);
    #1 host_wr = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk);
    #1 host_rd = 0;
  endtask

  task automatic push_wbyte(input logic [7:0] b);
    reg_write(A_WDATA, {24'b0, b});
    wq_model.push_back(b);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      reg_read(A_STATUS, s);
      if (s[0]) return;
    end
    chk("R8 idle timeout", 0, 1);
  endtask

  task automatic run_burst(input string tag, input int len_val, input logic [3:0] cmd,
                           input logic [31:0] base, input int err_idx, input bit dbl);
    int n, n_eff;
    logic [31:0] s;
    n = (len_val == 0 || len_val > 16) ? 16 : len_val;
    n_eff = (err_idx >= 0) ? err_idx + 1 : n;
    exp_rd.delete();
    for (int i = 0; i < n_eff; i++) begin
      op_t e;
      e.w = cmd[0];
      e.kind = cmd[2:1];
      e.addr = cmd[3] ? base : base + i;
      e.wb = 8'h00;
      if (cmd[0] && wq_model.size() > 0) e.wb = wq_model.pop_front();
      exp_ops.push_back(e);
      if (!cmd[0] && i != err_idx) exp_rd.push_back(e.addr[7:0] ^ 8'hA5);
    end
    op_idx = 0;
    err_at = err_idx;
    reg_write(A_LEN, len_val);
    reg_write(A_CMD, {28'b0, cmd});
    reg_write(A_TADDR, base);
    reg_write(A_START, 32'h1);
    if (dbl) begin
      reg_read(A_STATUS, s);
      chk("R8 busy status", {31'b0, s[0]}, 0);
      reg_write(A_START, 32'h1);
    end
    wait_idle();
    repeat (2) @(negedge clk);
    $display("burst %s done", tag);
    chk("R2 op count", op_idx, n_eff);
    chk("R2 ops left", exp_ops.size(), 0);
    exp_ops.delete();
    reg_read(A_STATUS, s);
    chk("R8 final status", s, (err_idx >= 0) ? 32'h1 : 32'h3);
    reg_read(A_IRQ, s);
    chk("R9 irq set", s, 32'h2);
    chk("R9 irq_o", {31'b0, irq_o}, 1);
    err_at = -1;
  endtask

  task automatic drain(input string req);
    logic [31:0] d;
    while (exp_rd.size() > 0) begin
      logic [7:0] e;
      e = exp_rd.pop_front();
      reg_read(A_RDATA, d);
      chk(req, d, {24'b0, e});
    end
    reg_read(A_RDATA, d);
    chk("R7 empty read", d, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    report();
  end

  initial begin : stim
    logic [31:0] d;
    rst_n = 0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_read(A_STATUS, d); chk("R1 status", d, 32'h1);
    reg_read(A_IRQ, d);    chk("R1 irq", d, 32'h0);
    reg_read(A_RDATA, d);  chk("R1 rdata", d, 32'h0);
    chk("R1 irq_o", {31'b0, irq_o}, 0);

    // R6 R5 write burst, stepping address, I/O kind
    push_wbyte(8'h11); push_wbyte(8'h22); push_wbyte(8'h33);
    run_burst("R6 write inc", 3, 4'b0001, 32'h60, -1, 0);
    // R9 writing 0 leaves flag, writing 1 clears
    reg_write(A_IRQ, 32'h0);
    reg_read(A_IRQ, d); chk("R9 write0 keeps", d, 32'h2);
    reg_write(A_IRQ, 32'h2);
    reg_read(A_IRQ, d); chk("R9 cleared", d, 32'h0);
    chk("R9 irq_o cleared", {31'b0, irq_o}, 0);

    // R5 R7 read burst on one address, memory kind
    run_burst("R5 read same", 4, 4'b1010, 32'h3F8, -1, 0);
    drain("R7 read order");
    reg_write(A_IRQ, 32'h2);

    // R4 firmware hub kind, stepping read
    run_burst("R4 fwhub", 2, 4'b0100, 32'hFF00_0010, -1, 0);
    drain("R7 fwhub data");

    // R3 length 0 and above 16
    run_burst("R3 len0", 0, 4'b0000, 32'h100, -1, 0);
    drain("R3 len0 data");
    run_burst("R3 len20", 20, 4'b0000, 32'h200, -1, 0);
    // R11 start flushes unread bytes
    run_burst("R11 flush", 1, 4'b0000, 32'h7, -1, 0);
    drain("R11 after flush");

    // R6 write with empty queue sends zero
    run_burst("R6 empty wq", 2, 4'b1001, 32'h80, -1, 0);

    // R10 start while busy ignored
    eng_lat = 4;
    run_burst("R10 busy start", 2, 4'b0000, 32'h40, -1, 1);
    drain("R10 data");
    eng_lat = 2;

    // R8 engine error aborts
    reg_write(A_IRQ, 32'h2);
    push_wbyte(8'hA1); push_wbyte(8'hA2); push_wbyte(8'hA3); push_wbyte(8'hA4);
    run_burst("R8 error", 4, 4'b0001, 32'h90, 1, 0);

    done_flag = 1;
    report();
  end

endmodule